// File: doc/BRIEF.md
# Keyed Index/Data Configuration Register File

This block holds the configuration bytes of a system chipset and exposes them to the host through two I/O addresses. A write to the index port selects one of 256 byte-wide registers. A write to the data port stores a byte into the selected register, and a read of the data port returns it. A key register guards the whole file. While the key register does not hold the unlock code, every data write to any other register is dropped. Several registers keep only some of the bits written to them. The rest read back as zero.

A small two-state lock machine follows the key. In state `LK_LOCKED` only the key register accepts writes. Transition `UNLOCK` happens when 0xC5 is written to index 0x03, and moves to `LK_OPEN`. In `LK_OPEN` every register accepts writes. Transition `RELOCK` happens when any other value is written to index 0x03, and returns to `LK_LOCKED`. Reset enters `LK_LOCKED`.

Three kinds of side-effect output come straight from the file: two cache enables, a fast-reset/A20 port enable, and a one-cycle SMI request. A compatibility input hides certain indices from data-port reads. This leaves those indices free for registers that a processor decodes at the same I/O addresses.

Top module: `cfgrf_top`

## Requirements
- R1: A write to I/O address 0x22 latches the index. A read at address 0x23 returns the register at that index, combinationally, in the same cycle.
- R2: Register 0x03 accepts every data write. Every other register accepts data writes only while register 0x03 holds 0xC5. A rejected write leaves the register unchanged.
- R3: An accepted write stores the data ANDed with a per-register mask. The masks are: 0x14→0xBF, 0x15→0xF1, 0x1E→0x40, 0x22→0xFD, 0x2B→0xBF, 0x36→0xE5, 0x37→0xEF, 0x3D→0x07, 0x40→0x3F. All other registers use mask 0xFF.
- R4: While `compat_mode` is high, a data-port read at index 0x20, or at any index of 0xC0 or above, returns 0xFF. When `compat_mode` is low again, the stored values read back.
- R5: `cache_int_en` equals bit 0 of register 0x16, and `cache_ext_en` equals bit 1 of that register.
- R6: `port92_en` equals bit 4 of register 0x29.
- R7: An accepted write to register 0x35 whose data has bit 4 or bit 5 set raises `smi_req` for exactly the one cycle after the write edge. Any other write leaves `smi_req` low.
- R8: A read at any address other than 0x23 returns 0xFF.
- R9: After reset the following registers hold these values, and all other registers hold 0x00: 0x01=0x0F, 0x02=0x0F, 0x10=0xF1, 0x11=0xFF, 0x15=0x20, 0x16=0x30, 0x19=0x04, 0x21=0x72, 0x28=0x02, 0x2B=0xDB, 0x3C=0x03, 0x3D=0x01, 0x40=0x03.
- R10: Writing a value other than 0xC5 to register 0x03 locks the file again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one transfer per cycle |
| io_addr | input | AW (16) | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the current address |
| compat_mode | input | 1 | Hides index 0x20 and indices at or above 0xC0 from reads |
| cache_int_en | output | 1 | Internal cache enable |
| cache_ext_en | output | 1 | External cache enable |
| port92_en | output | 1 | Fast-reset/A20 port enable |
| smi_req | output | 1 | One-cycle SMI request |

## Verification
Almost all state is visible at the ports in the same cycle. A wrong stored byte appears on `io_rdata` as soon as the index selects it. A wrong lock state shows up at the next data write, which either lands or is dropped. A wrong value in register 0x16 or register 0x29 changes a side output one edge after the write. A fault in the SMI path shows as a missing, extra or stretched pulse in the cycle after the write. The reference model is compared against every output on every clock, with random traffic added to the directed cases.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

    localparam logic [7:0] KEY_IDX    = 8'h03;
    localparam logic [7:0] KEY_CODE   = 8'hC5;
    localparam logic [7:0] CACHE_IDX  = 8'h16;
    localparam logic [7:0] P92_IDX    = 8'h29;
    localparam logic [7:0] SMI_IDX    = 8'h35;
    localparam logic [7:0] HIDE_IDX   = 8'h20;
    localparam logic [7:0] HIDE_FLOOR = 8'hC0;
    localparam logic [7:0] SMI_BITS   = 8'h30;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

    // R9: power-on contents
    function automatic logic [7:0] reset_value(input int unsigned i);
        logic [7:0] v;
        unique case (i)
            32'h01, 32'h02: v = 8'h0F;
            32'h10:         v = 8'hF1;
            32'h11:         v = 8'hFF;
            32'h15:         v = 8'h20;
            32'h16:         v = 8'h30;
            32'h19:         v = 8'h04;
            32'h21:         v = 8'h72;
            32'h28:         v = 8'h02;
            32'h2B:         v = 8'hDB;
            32'h3C:         v = 8'h03;
            32'h3D:         v = 8'h01;
            32'h40:         v = 8'h03;
            default:        v = 8'h00;
        endcase
        return v;
    endfunction

    // R3: bits each register keeps on a write
    function automatic logic [7:0] write_mask(input int unsigned i);
        logic [7:0] m;
        unique case (i)
            32'h14, 32'h2B: m = 8'hBF;
            32'h15:         m = 8'hF1;
            32'h1E:         m = 8'h40;
            32'h22:         m = 8'hFD;
            32'h36:         m = 8'hE5;
            32'h37:         m = 8'hEF;
            32'h3D:         m = 8'h07;
            32'h40:         m = 8'h3F;
            default:        m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfgrf_port_decode.sv
module cfgrf_port_decode #(
    parameter int          AW         = 16,
    parameter logic [15:0] INDEX_PORT = 16'h0022,
    parameter logic [15:0] DATA_PORT  = 16'h0023
) (
    input  logic          io_wr,
    input  logic [AW-1:0] io_addr,
    output logic          idx_wr,
    output logic          data_wr,
    output logic          data_sel
);
    always_comb begin
        data_sel = (io_addr == AW'(DATA_PORT));
        idx_wr   = io_wr && (io_addr == AW'(INDEX_PORT));
        data_wr  = io_wr && data_sel;
    end
endmodule

// File: rtl/cfgrf_index_reg.sv
module cfgrf_index_reg #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [7:0]       wdata,
    output logic [IDX_W-1:0] idx_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= wdata[IDX_W-1:0];
    end
endmodule

// File: rtl/cfgrf_lock_fsm.sv
module cfgrf_lock_fsm
    import cfgrf_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic             wr_accept,
    output logic             smi_pulse,
    output lock_state_e      state_q
);
    lock_state_e state_d;
    logic        key_hit;

    assign key_hit = data_wr && (idx == IDX_W'(KEY_IDX));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_hit && wdata == KEY_CODE) state_d = LK_OPEN;   // UNLOCK
            LK_OPEN:   if (key_hit && wdata != KEY_CODE) state_d = LK_LOCKED; // RELOCK
            default:   state_d = LK_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        wr_accept = key_hit || (data_wr && state_q == LK_OPEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smi_pulse <= 1'b0;
        else        smi_pulse <= wr_accept && (idx == IDX_W'(SMI_IDX)) &&
                                 ((wdata & SMI_BITS) != 8'h00);
    end
endmodule

// File: rtl/cfgrf_store.sv
module cfgrf_store
    import cfgrf_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int NREG = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       regs [NREG]
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] RST  = reset_value(g);
        localparam logic [7:0] MASK = write_mask(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= RST;
            else if (we && idx == IDX_W'(g))
                regs[g] <= wdata & MASK;
        end
    end
endmodule

// File: rtl/cfgrf_top.sv
module cfgrf_top
    import cfgrf_pkg::*;
#(
    parameter int          AW         = 16,
    parameter logic [15:0] INDEX_PORT = 16'h0022,
    parameter logic [15:0] DATA_PORT  = 16'h0023
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_wr,
    input  logic [AW-1:0] io_addr,
    input  logic [7:0]    io_wdata,
    output logic [7:0]    io_rdata,
    input  logic          compat_mode,
    output logic          cache_int_en,
    output logic          cache_ext_en,
    output logic          port92_en,
    output logic          smi_req
);
    localparam int IDX_W = 8;
    localparam int NREG  = 1 << IDX_W;

    logic             idx_wr, data_wr, data_sel, wr_accept;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       regs [NREG];
    logic [7:0]       sel_val;
    logic [7:0]       key_q;
    logic             hidden;
    lock_state_e      lock_state;

    cfgrf_port_decode #(.AW(AW), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)) u_dec (
        .io_wr(io_wr), .io_addr(io_addr),
        .idx_wr(idx_wr), .data_wr(data_wr), .data_sel(data_sel)
    );

    cfgrf_index_reg #(.IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata), .idx_q(idx_q)
    );

    cfgrf_lock_fsm #(.IDX_W(IDX_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx(idx_q), .wdata(io_wdata),
        .wr_accept(wr_accept), .smi_pulse(smi_req), .state_q(lock_state)
    );

    cfgrf_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_accept), .idx(idx_q),
        .wdata(io_wdata), .regs(regs)
    );

    always_comb begin
        sel_val      = regs[idx_q];
        key_q        = regs[KEY_IDX];
        hidden       = compat_mode && (idx_q == HIDE_IDX || idx_q >= HIDE_FLOOR);
        io_rdata     = (data_sel && !hidden) ? sel_val : 8'hFF;
        cache_int_en = regs[CACHE_IDX][0];
        cache_ext_en = regs[CACHE_IDX][1];
        port92_en    = regs[P92_IDX][4];
    end
endmodule

// File: rtl/cfgrf_chk.sv
module cfgrf_chk #(
    parameter int          AW        = 16,
    parameter logic [15:0] DATA_PORT = 16'h0023
) (
    input logic          clk,
    input logic          rst_n,
    input logic          io_wr,
    input logic [AW-1:0] io_addr,
    input logic [7:0]    io_wdata,
    input logic [7:0]    io_rdata,
    input logic          compat_mode,
    input logic          cache_int_en,
    input logic          port92_en,
    input logic          smi_req,
    input logic [7:0]    idx_q,
    input logic [7:0]    key_q,
    input logic [7:0]    sel_val
);
    logic dwr;
    assign dwr = io_wr && io_addr == AW'(DATA_PORT);

    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && key_q != 8'hC5 && idx_q != 8'h03) |=> $stable(sel_val));

    assert_mask_3d_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && key_q == 8'hC5 && idx_q == 8'h3D) |=> sel_val == ($past(io_wdata) & 8'h07));

    assert_hide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (compat_mode && io_addr == AW'(DATA_PORT) && (idx_q == 8'h20 || idx_q >= 8'hC0))
        |-> io_rdata == 8'hFF);

    assert_cache_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && key_q == 8'hC5 && idx_q == 8'h16) |=> cache_int_en == $past(io_wdata[0]));

    assert_p92_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && key_q == 8'hC5 && idx_q == 8'h29) |=> port92_en == $past(io_wdata[4]));

    assert_smi_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> $past(dwr && key_q == 8'hC5 && idx_q == 8'h35 && (io_wdata & 8'h30) != 8'h00));

    assert_other_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != AW'(DATA_PORT)) |-> io_rdata == 8'hFF);
endmodule

bind cfgrf_top cfgrf_chk #(.AW(AW), .DATA_PORT(DATA_PORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .compat_mode(compat_mode), .cache_int_en(cache_int_en),
    .port92_en(port92_en), .smi_req(smi_req), .idx_q(idx_q), .key_q(key_q),
    .sel_val(sel_val)
);

// File: tb/cfgrf_tb.sv
module cfgrf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        compat_mode = 1'b0;
    logic        cache_int_en, cache_ext_en, port92_en, smi_req;

    always #4 clk = ~clk;

    cfgrf_top dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .compat_mode(compat_mode), .cache_int_en(cache_int_en),
        .cache_ext_en(cache_ext_en), .port92_en(port92_en), .smi_req(smi_req)
    );

    int   tests = 0;
    int   fails = 0;
    bit   done = 0;
    byte unsigned model [256];
    byte unsigned m_idx;
    bit   m_smi;

    function automatic byte unsigned dflt(int i);
        case (i)
            'h01, 'h02: return 8'h0F;
            'h10: return 8'hF1;  'h11: return 8'hFF;  'h15: return 8'h20;
            'h16: return 8'h30;  'h19: return 8'h04;  'h21: return 8'h72;
            'h28: return 8'h02;  'h2B: return 8'hDB;  'h3C: return 8'h03;
            'h3D: return 8'h01;  'h40: return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    function automatic byte unsigned keep(int i);
        case (i)
            'h14, 'h2B: return 8'hBF;  'h15: return 8'hF1;  'h1E: return 8'h40;
            'h22: return 8'hFD;  'h36: return 8'hE5;  'h37: return 8'hEF;
            'h3D: return 8'h07;  'h40: return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic byte unsigned exp_rd();
        if (io_addr != 16'h0023) return 8'hFF;
        if (compat_mode && (m_idx == 8'h20 || m_idx >= 8'hC0)) return 8'hFF;
        return model[m_idx];
    endfunction

    // every-cycle comparison against the reference model
    task automatic compare_all();
        check("R1/R4/R8 rdata", io_rdata, exp_rd());
        check("R5 cache_int", cache_int_en, model[8'h16][0]);
        check("R5 cache_ext", cache_ext_en, model[8'h16][1]);
        check("R6 port92", port92_en, model[8'h29][4]);
        check("R7 smi", smi_req, m_smi);
    endtask

    task automatic cyc(bit wr, logic [15:0] a, byte unsigned d);
        @(negedge clk);
        io_wr = wr; io_addr = a; io_wdata = d;
        @(posedge clk);
        #2;
        m_smi = 0;
        if (wr && a == 16'h0022) m_idx = d;
        else if (wr && a == 16'h0023 && (m_idx == 8'h03 || model[3] == 8'hC5)) begin
            model[m_idx] = d & keep(m_idx);
            if (m_idx == 8'h35 && (d & 8'h30) != 0) m_smi = 1;
        end
        compare_all();
    endtask

    task automatic wr_reg(byte unsigned i, byte unsigned d);
        cyc(1, 16'h0022, i);
        cyc(1, 16'h0023, d);
    endtask

    task automatic rd_reg(byte unsigned i, string tag, byte unsigned exp);
        cyc(1, 16'h0022, i);
        cyc(0, 16'h0023, 8'h00);
        check(tag, io_rdata, exp);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = dflt(i);
        m_idx = 0; m_smi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R9 defaults over the whole file
        for (int i = 0; i < 256; i++) rd_reg(i[7:0], "R9 default", dflt(i));
        check("R9 cache_int", cache_int_en, 0);

        // R2 locked write has no effect
        wr_reg(8'h16, 8'h03);
        rd_reg(8'h16, "R2 locked", 8'h30);
        check("R2 cache_int locked", cache_int_en, 0);
        wr_reg(8'h03, 8'h12);
        wr_reg(8'h10, 8'h00);
        rd_reg(8'h10, "R2 wrong key", 8'hF1);
        rd_reg(8'h03, "R2 key always writable", 8'h12);

        // unlock, then side outputs
        wr_reg(8'h03, 8'hC5);
        wr_reg(8'h16, 8'h03);
        check("R5 both caches on", {cache_ext_en, cache_int_en}, 3);
        wr_reg(8'h16, 8'h02);
        check("R5 ext only", {cache_ext_en, cache_int_en}, 2);
        wr_reg(8'h29, 8'h10);
        check("R6 port92 on", port92_en, 1);
        wr_reg(8'h29, 8'hEF);
        check("R6 port92 off", port92_en, 0);

        // R3 masks
        foreach (model[i]) if (keep(i) != 8'hFF) begin
            wr_reg(i[7:0], 8'hFF);
            rd_reg(i[7:0], "R3 mask", keep(i));
        end

        // R7 SMI pulse
        wr_reg(8'h35, 8'h10);
        check("R7 pulse bit4", smi_req, 1);
        cyc(0, 16'h0023, 8'h00);
        check("R7 single cycle", smi_req, 0);
        wr_reg(8'h35, 8'h01);
        check("R7 no pulse", smi_req, 0);
        cyc(1, 16'h0023, 8'h20);
        check("R7 pulse bit5", smi_req, 1);
        cyc(1, 16'h0023, 8'h20);
        check("R7 back-to-back", smi_req, 1);

        // R4 compatibility hiding
        wr_reg(8'h20, 8'h5A);
        wr_reg(8'hC0, 8'h11);
        wr_reg(8'hFF, 8'h22);
        compat_mode = 1'b1;
        rd_reg(8'h20, "R4 hide 20", 8'hFF);
        rd_reg(8'hC0, "R4 hide C0", 8'hFF);
        rd_reg(8'hFF, "R4 hide FF", 8'hFF);
        rd_reg(8'h21, "R4 visible 21", 8'h72);
        rd_reg(8'hBF, "R4 visible BF", 8'h00);
        compat_mode = 1'b0;
        rd_reg(8'h20, "R4 back 20", 8'h5A);
        rd_reg(8'hC0, "R4 back C0", 8'h11);

        // R8 other addresses
        cyc(0, 16'h0022, 8'h00);
        check("R8 index port read", io_rdata, 8'hFF);
        cyc(0, 16'h0080, 8'h00);
        check("R8 other address", io_rdata, 8'hFF);

        // R10 relock
        wr_reg(8'h03, 8'h00);
        wr_reg(8'h21, 8'h99);
        rd_reg(8'h21, "R10 relocked", 8'h72);

        // random traffic with every-cycle comparison
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 9);
            compat_mode = ($urandom_range(0, 7) == 0);
            if (r < 3)      cyc(1, 16'h0022, 8'($urandom_range(0, 255)));
            else if (r < 6) cyc(1, 16'h0023, ($urandom_range(0, 3) == 0) ? 8'hC5
                                             : 8'($urandom_range(0, 255)));
            else if (r < 9) cyc(0, 16'h0023, 8'h00);
            else            cyc($urandom_range(0, 1) == 1, 16'($urandom_range(0, 65535)),
                                8'($urandom_range(0, 255)));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule